// File: doc/BRIEF.md
# SCSI Host-Adapter Register Window

This block is the byte-wide register interface that a CPU uses to control a simple SCSI host adapter. Sixteen byte registers sit on a four-byte address stride. Reads and writes go to separate banks. Writing one register issues a command. Commands that change only local state take effect inside the block. Commands that need bus phase sequencing are passed to an external sequencer as a one-cycle strobe. The sequencer and the DMA engine are outside this block. The sequencer reports back through a status-set port that loads the status, interrupt-reason and sequence-step registers and may raise the interrupt.

The CPU moves data through a 32-byte FIFO. A write to the FIFO register pushes a byte, and a read from it pops the oldest byte. While the sequencer signals command phase, FIFO writes go into a separate 32-byte command buffer, which the sequencer reads through an index port. Reading the interrupt-reason register acknowledges the interrupt. A chip-reset command, or the chip-reset pin, returns every register to its reset value and leaves only the identification byte set.

Top module: `hba_regwin`

## Requirements
- R1: The register index is bus_addr[5:2]. Address bits [1:0] have no effect on which register is accessed.
- R2: Writes to registers 8 and 12–15 read back unchanged. Register 11 reads back the written value ANDed with 0x15. Registers 9 and 10 always read 0x00. A write to register 0 or 1 does not change what those registers read.
- R3: A write to register 0 or register 1 clears bit 4 (0x10) of the status register (register 4) and leaves its other bits unchanged.
- R4: A write to the command register (register 3) with bit 7 set drives cmd_dma high and copies the values last written to registers 0 and 1 into their readable copies. With bit 7 clear, cmd_dma goes low and the readable copies are kept. Register 3 reads back the last command byte.
- R5: Opcode 0x01 (flush) sets the interrupt reason (register 5) to 0x08 and the sequence step (register 6) to 0.
- R6: Opcode 0x03 (bus reset) sets the interrupt reason to 0x80. It raises irq unless bit 6 of register 8 is set.
- R7: Opcodes 0x10, 0x11, 0x12, 0x42 and 0x43 (low 7 bits of the command byte) produce a one-cycle cmd_stb in the cycle after the write, with cmd_op equal to the opcode. No other opcode produces a strobe. Opcodes 0x1a, 0x44 and unlisted opcodes leave the interrupt reason unchanged.
- R8: Reading register 5 returns the interrupt reason unchanged. From the next cycle, status bits 7, 6 and 5 are cleared and irq is low.
- R9: Outside command phase, a write to register 2 pushes a byte into a 32-entry FIFO. Writes to a full FIFO are dropped. Register 7 reads the current count. A read of register 2 returns the oldest byte and removes it. A read of an empty FIFO returns 0x00 and changes nothing. Byte order is preserved across refills.
- R10: While cmd_phase is high, register 2 writes store bytes in the command buffer and do not enter the FIFO. Writes after 32 bytes are dropped. cbuf_len gives the number of stored bytes, cbuf_byte returns the entry selected by cbuf_sel, and cbuf_clr empties the buffer.
- R11: Opcode 0x02 and the chip_rst pin both clear all readable registers, the FIFO, irq and cmd_dma. After either one, register 14 reads 0x04.
- R12: seq_set loads the status, interrupt-reason and step registers from the seq_* inputs. It raises irq when seq_irq is high. In the same cycle it takes priority over an interrupt acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_rst | input | 1 | Synchronous chip reset |
| bus_addr | input | 6 | Byte address; register index is [5:2] |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| cmd_stb | output | 1 | One-cycle strobe for a forwarded command |
| cmd_op | output | 7 | Opcode of the forwarded command |
| cmd_dma | output | 1 | DMA mode selected by the last command |
| cmd_phase | input | 1 | Steers FIFO writes into the command buffer |
| cbuf_clr | input | 1 | Empties the command buffer |
| cbuf_sel | input | 5 | Command buffer read index |
| cbuf_len | output | 6 | Number of bytes in the command buffer |
| cbuf_byte | output | 8 | Command buffer entry at cbuf_sel |
| seq_set | input | 1 | Load status, reason and step from the sequencer |
| seq_irq | input | 1 | Raise irq with seq_set |
| seq_status | input | 8 | New status register value |
| seq_reason | input | 8 | New interrupt reason value |
| seq_step | input | 3 | New sequence step value |

## Verification
Most internal state is visible only through later reads. If the FIFO pointers return to zero at the wrong moment, the error shows as wrong byte order the first time the FIFO is refilled after being drained. The bench therefore drains, refills and reads again. If the count reload latches the wrong bank, the count register reads the wrong value on the very next access. A mistake in acknowledge or bus-reset masking shows on irq one cycle after the triggering access. A fault in command decode shows on cmd_stb in the cycle after the write, or as a changed interrupt reason on the next read of register 5.

// File: rtl/hba_regwin.sv
module hba_regwin #(
  parameter int FIFO_DEPTH = 32,
  parameter int CBUF_DEPTH = 32,
  parameter logic [7:0] CHIP_ID = 8'h04
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chip_rst,
  input  logic [5:0]                    bus_addr,
  input  logic [7:0]                    bus_wdata,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  output logic [7:0]                    bus_rdata,
  output logic                          irq,
  output logic                          cmd_stb,
  output logic [6:0]                    cmd_op,
  output logic                          cmd_dma,
  input  logic                          cmd_phase,
  input  logic                          cbuf_clr,
  input  logic [$clog2(CBUF_DEPTH)-1:0] cbuf_sel,
  output logic [$clog2(CBUF_DEPTH):0]   cbuf_len,
  output logic [7:0]                    cbuf_byte,
  input  logic                          seq_set,
  input  logic                          seq_irq,
  input  logic [7:0]                    seq_status,
  input  logic [7:0]                    seq_reason,
  input  logic [2:0]                    seq_step
);
  localparam int FW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(CBUF_DEPTH);
  localparam logic [3:0] IX_CNT_LO = 4'd0;
  localparam logic [3:0] IX_CNT_HI = 4'd1;
  localparam logic [3:0] IX_FIFO   = 4'd2;
  localparam logic [3:0] IX_CMD    = 4'd3;
  localparam logic [3:0] IX_STAT   = 4'd4;
  localparam logic [3:0] IX_RSN    = 4'd5;
  localparam logic [3:0] IX_STEP   = 4'd6;
  localparam logic [3:0] IX_FCNT   = 4'd7;
  localparam logic [3:0] IX_CFG    = 4'd8;
  localparam logic [3:0] IX_MSK    = 4'd11;
  localparam logic [3:0] IX_ID     = 4'd14;

  logic [3:0] idx;
  logic [6:0] op;
  logic       cmd_wr, soft_rst, clr_all, fwd;
  logic       unused_addr;

  assign idx      = bus_addr[5:2];
  assign op       = bus_wdata[6:0];
  assign cmd_wr   = bus_wr && idx == IX_CMD;
  assign soft_rst = cmd_wr && op == 7'h02;
  assign clr_all  = chip_rst || soft_rst;
  assign fwd      = op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h42 || op == 7'h43;
  assign unused_addr = &{1'b0, bus_addr[1:0]};

  // write-side count bytes and readable bank
  logic [7:0] wcnt_lo, wcnt_hi;
  logic [7:0] rbank [16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_lo <= '0;
      wcnt_hi <= '0;
    end else if (clr_all) begin
      wcnt_lo <= '0;
      wcnt_hi <= '0;
    end else if (bus_wr && idx == IX_CNT_LO) begin
      wcnt_lo <= bus_wdata;
    end else if (bus_wr && idx == IX_CNT_HI) begin
      wcnt_hi <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rbank[i] <= (i == int'(IX_ID)) ? CHIP_ID : 8'h00;
    end else if (clr_all) begin
      for (int i = 0; i < 16; i++) rbank[i] <= (i == int'(IX_ID)) ? CHIP_ID : 8'h00;
    end else if (bus_wr) begin
      if (idx == IX_CFG || idx >= 4'd12) rbank[idx] <= bus_wdata;
      else if (idx == IX_MSK) rbank[idx] <= bus_wdata & 8'h15;
      else if (idx == IX_CMD) begin
        rbank[IX_CMD] <= bus_wdata;
        if (bus_wdata[7]) begin
          rbank[IX_CNT_LO] <= wcnt_lo;
          rbank[IX_CNT_HI] <= wcnt_hi;
        end
      end
    end
  end

  // status, interrupt reason, sequence step, interrupt line
  logic [7:0] st_q, rs_q;
  logic [2:0] sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0; rs_q <= '0; sq_q <= '0; irq <= 1'b0;
    end else if (clr_all) begin
      st_q <= '0; rs_q <= '0; sq_q <= '0; irq <= 1'b0;
    end else begin
      if (bus_rd && idx == IX_RSN) begin
        st_q[7:5] <= 3'b000;
        irq <= 1'b0;
      end
      if (bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_HI)) st_q[4] <= 1'b0;
      if (cmd_wr && op == 7'h01) begin
        rs_q <= 8'h08;
        sq_q <= 3'd0;
      end
      if (cmd_wr && op == 7'h03) begin
        rs_q <= 8'h80;
        if (!rbank[IX_CFG][6]) irq <= 1'b1;
      end
      if (seq_set) begin
        st_q <= seq_status;
        rs_q <= seq_reason;
        sq_q <= seq_step;
        if (seq_irq) irq <= 1'b1;
      end
    end
  end

  // command decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb <= 1'b0; cmd_op <= '0; cmd_dma <= 1'b0;
    end else if (clr_all) begin
      cmd_stb <= 1'b0; cmd_op <= '0; cmd_dma <= 1'b0;
    end else begin
      cmd_stb <= cmd_wr && fwd;
      if (cmd_wr) cmd_dma <= bus_wdata[7];
      if (cmd_wr && fwd) cmd_op <= op;
    end
  end

  // data FIFO
  logic [7:0]  fmem [FIFO_DEPTH];
  logic [FW-1:0] fwp, frp, fwp_n, frp_n;
  logic [FW:0]   fcnt, fcnt_n;
  logic          push, pop;

  assign push = bus_wr && idx == IX_FIFO && !cmd_phase && fcnt < (FW+1)'(FIFO_DEPTH);
  assign pop  = bus_rd && idx == IX_FIFO && fcnt != '0;

  always_comb begin
    fcnt_n = fcnt + (FW+1)'(push) - (FW+1)'(pop);
    fwp_n  = push ? ((fwp == FW'(FIFO_DEPTH-1)) ? '0 : fwp + 1'b1) : fwp;
    frp_n  = pop  ? ((frp == FW'(FIFO_DEPTH-1)) ? '0 : frp + 1'b1) : frp;
    if (fcnt_n == '0) begin
      fwp_n = '0;
      frp_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0; fwp <= '0; frp <= '0;
    end else if (clr_all) begin
      fcnt <= '0; fwp <= '0; frp <= '0;
    end else begin
      fcnt <= fcnt_n; fwp <= fwp_n; frp <= frp_n;
    end
  end

  always_ff @(posedge clk) if (push) fmem[fwp] <= bus_wdata;

  // command buffer
  logic [7:0] cbuf [CBUF_DEPTH];
  logic       cb_push;

  assign cb_push = bus_wr && idx == IX_FIFO && cmd_phase && cbuf_len < (CW+1)'(CBUF_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cbuf_len <= '0;
    else if (clr_all || cbuf_clr) cbuf_len <= '0;
    else if (cb_push) cbuf_len <= cbuf_len + 1'b1;
  end

  always_ff @(posedge clk) if (cb_push) cbuf[cbuf_len[CW-1:0]] <= bus_wdata;

  assign cbuf_byte = cbuf[cbuf_sel];

  // read mux
  always_comb begin
    case (idx)
      IX_FIFO: bus_rdata = (fcnt != '0) ? fmem[frp] : 8'h00;
      IX_STAT: bus_rdata = st_q;
      IX_RSN:  bus_rdata = rs_q;
      IX_STEP: bus_rdata = {5'b0, sq_q};
      IX_FCNT: bus_rdata = 8'(fcnt);
      default: bus_rdata = rbank[idx];
    endcase
  end

  // R8
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IX_RSN && !seq_set) |=> !irq);

  // R3
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_HI) && !seq_set) |=> !st_q[4]);

  // R6
  busrst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == 7'h03 && rbank[IX_CFG][6] && !irq && !seq_set && !chip_rst) |=> !irq);

  // R7
  cmd_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(bus_wr) && $past(bus_addr[5:2]) == IX_CMD));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IX_FIFO && !cmd_phase && fcnt == (FW+1)'(FIFO_DEPTH) && !chip_rst) |=> $stable(fcnt));

  // R11
  chip_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> (!irq && !cmd_dma && fcnt == '0 && !cmd_stb));
endmodule

// File: tb/hba_regwin_bench.sv
module hba_regwin_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_rst = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq, cmd_stb, cmd_dma;
  logic [6:0] cmd_op;
  logic       cmd_phase = 1'b0, cbuf_clr = 1'b0;
  logic [4:0] cbuf_sel = '0;
  logic [5:0] cbuf_len;
  logic [7:0] cbuf_byte;
  logic       seq_set = 1'b0, seq_irq = 1'b0;
  logic [7:0] seq_status = '0, seq_reason = '0;
  logic [2:0] seq_step = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  hba_regwin u_hba_regwin (
    .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq(irq), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_dma(cmd_dma), .cmd_phase(cmd_phase), .cbuf_clr(cbuf_clr),
    .cbuf_sel(cbuf_sel), .cbuf_len(cbuf_len), .cbuf_byte(cbuf_byte),
    .seq_set(seq_set), .seq_irq(seq_irq), .seq_status(seq_status),
    .seq_reason(seq_reason), .seq_step(seq_step)
  );

  // monitor: compares read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic seq(input logic [7:0] s, input logic [7:0] r, input logic [2:0] p, input logic i);
    @(posedge clk); #1;
    seq_status = s; seq_reason = r; seq_step = p; seq_irq = i; seq_set = 1'b1;
    @(posedge clk); #1;
    seq_set = 1'b0; seq_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    rd(6'h38, 8'h04, "R11 id after reset");
    rd(6'h10, 8'h00, "R11 status after reset");
    rd(6'h1C, 8'h00, "R11 fifo count after reset");
    check("R11 irq after reset", irq, 0);

    // R1 low address bits ignored
    wr(6'h33, 8'h5A);
    rd(6'h30, 8'h5A, "R1 index from addr[5:2]");
    rd(6'h32, 8'h5A, "R1 offset 2 same register");

    // R2 readback masking
    wr(6'h20, 8'h3C);
    rd(6'h22, 8'h3C, "R2 reg8 readback");
    wr(6'h2C, 8'hFF);
    rd(6'h2C, 8'h15, "R2 reg11 masked");
    wr(6'h24, 8'hAA);
    rd(6'h24, 8'h00, "R2 reg9 reads zero");
    wr(6'h00, 8'h34);
    rd(6'h00, 8'h00, "R2 count write not visible");

    // R4 DMA reload
    wr(6'h04, 8'h12);
    wr(6'h0C, 8'h80);
    check("R4 cmd_dma set", cmd_dma, 1);
    check("R7 nop no strobe", cmd_stb, 0);
    rd(6'h00, 8'h34, "R4 count lo reloaded");
    rd(6'h04, 8'h12, "R4 count hi reloaded");
    rd(6'h0C, 8'h80, "R4 command readback");
    wr(6'h00, 8'h99);
    wr(6'h0C, 8'h00);
    check("R4 cmd_dma clear", cmd_dma, 0);
    rd(6'h00, 8'h34, "R4 no reload without bit7");

    // R12 sequencer load
    seq(8'h91, 8'h18, 3'd4, 1'b1);
    check("R12 irq raised", irq, 1);
    rd(6'h10, 8'h91, "R12 status loaded");
    rd(6'h18, 8'h04, "R12 step loaded");

    // R3 terminal count clear
    wr(6'h04, 8'h55);
    rd(6'h10, 8'h81, "R3 bit4 cleared");

    // R8 acknowledge
    rd(6'h14, 8'h18, "R8 reason returned");
    check("R8 irq dropped", irq, 0);
    rd(6'h10, 8'h01, "R8 status bits cleared");
    rd(6'h14, 8'h18, "R8 reason kept");
    seq(8'hF3, 8'h22, 3'd2, 1'b0);
    check("R12 no irq without seq_irq", irq, 0);
    rd(6'h14, 8'h22, "R12 reason loaded");
    rd(6'h10, 8'h13, "R8 bits 7..5 cleared");

    // R5 flush
    wr(6'h0C, 8'h01);
    rd(6'h14, 8'h08, "R5 flush reason");
    rd(6'h18, 8'h00, "R5 flush step");
    rd(6'h10, 8'h13, "R5 status untouched");

    // R6 bus reset
    wr(6'h20, 8'h00);
    wr(6'h0C, 8'h03);
    check("R6 irq raised", irq, 1);
    rd(6'h14, 8'h80, "R6 reason");
    check("R8 irq cleared after bus reset", irq, 0);
    wr(6'h20, 8'h40);
    wr(6'h0C, 8'h01);
    wr(6'h0C, 8'h03);
    check("R6 irq masked", irq, 0);
    rd(6'h14, 8'h80, "R6 reason when masked");

    // R7 forwarding
    wr(6'h0C, 8'h10);
    check("R7 strobe 0x10", cmd_stb, 1);
    check("R7 op 0x10", cmd_op, 7'h10);
    @(posedge clk); #1;
    check("R7 strobe one cycle", cmd_stb, 0);
    wr(6'h0C, 8'hC3);
    check("R7 strobe 0x43", cmd_stb, 1);
    check("R7 op 0x43", cmd_op, 7'h43);
    check("R4 dma with 0x43", cmd_dma, 1);
    wr(6'h0C, 8'h11);
    check("R7 op 0x11", cmd_op, 7'h11);
    wr(6'h0C, 8'h12);
    check("R7 op 0x12", cmd_op, 7'h12);
    wr(6'h0C, 8'h42);
    check("R7 op 0x42", cmd_op, 7'h42);
    wr(6'h0C, 8'h1A);
    check("R7 0x1a no strobe", cmd_stb, 0);
    wr(6'h0C, 8'h44);
    check("R7 0x44 no strobe", cmd_stb, 0);
    wr(6'h0C, 8'h7F);
    check("R7 unlisted no strobe", cmd_stb, 0);
    rd(6'h14, 8'h80, "R7 reason unchanged");

    // R9 FIFO
    wr(6'h08, 8'hA1); wr(6'h08, 8'hB2); wr(6'h08, 8'hC3);
    rd(6'h1C, 8'h03, "R9 count 3");
    rd(6'h08, 8'hA1, "R9 pop 1");
    rd(6'h08, 8'hB2, "R9 pop 2");
    rd(6'h08, 8'hC3, "R9 pop 3");
    rd(6'h1C, 8'h00, "R9 count empty");
    rd(6'h08, 8'h00, "R9 empty read");
    for (int i = 0; i < 33; i++) wr(6'h08, 8'(i + 1));
    rd(6'h1C, 8'h20, "R9 count full");
    for (int i = 0; i < 32; i++) rd(6'h08, 8'(i + 1), "R9 full drain order");
    rd(6'h08, 8'h00, "R9 overflow byte dropped");
    wr(6'h08, 8'hD4); wr(6'h08, 8'hE5);
    rd(6'h08, 8'hD4, "R9 refill order 1");
    rd(6'h08, 8'hE5, "R9 refill order 2");

    // R10 command buffer
    cmd_phase = 1'b1;
    for (int i = 0; i < 34; i++) wr(6'h08, 8'(8'h40 + i));
    check("R10 length capped", cbuf_len, 32);
    cbuf_sel = 5'd0; #1;
    check("R10 first byte", cbuf_byte, 8'h40);
    cbuf_sel = 5'd31; #1;
    check("R10 last byte", cbuf_byte, 8'h5F);
    rd(6'h1C, 8'h00, "R10 fifo untouched");
    cmd_phase = 1'b0;
    @(posedge clk); #1 cbuf_clr = 1'b1;
    @(posedge clk); #1 cbuf_clr = 1'b0;
    check("R10 clear", cbuf_len, 0);

    // R12 priority over acknowledge
    seq(8'h80, 8'h10, 3'd1, 1'b1);
    @(posedge clk); #1;
    bus_addr = 6'h14; bus_rd = 1'b1;
    exp_q.push_back(8'h10); tag_q.push_back("R12 reason during collision");
    seq_status = 8'h90; seq_reason = 8'h20; seq_step = 3'd2; seq_irq = 1'b1; seq_set = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; seq_set = 1'b0; seq_irq = 1'b0;
    check("R12 irq kept over ack", irq, 1);
    rd(6'h10, 8'h90, "R12 status kept over ack");

    // R11 soft and pin reset
    wr(6'h20, 8'h3C);
    wr(6'h08, 8'h77);
    wr(6'h0C, 8'h82);
    check("R11 irq cleared", irq, 0);
    check("R11 dma cleared", cmd_dma, 0);
    rd(6'h20, 8'h00, "R11 reg8 cleared");
    rd(6'h30, 8'h00, "R11 reg12 cleared");
    rd(6'h38, 8'h04, "R11 id restored");
    rd(6'h1C, 8'h00, "R11 fifo emptied");
    rd(6'h14, 8'h00, "R11 reason cleared");
    rd(6'h10, 8'h00, "R11 status cleared");
    wr(6'h34, 8'h77);
    rd(6'h34, 8'h77, "R2 reg13 readback");
    @(posedge clk); #1 chip_rst = 1'b1;
    @(posedge clk); #1 chip_rst = 1'b0;
    rd(6'h34, 8'h00, "R11 pin clears reg13");
    rd(6'h38, 8'h04, "R11 pin id");

    @(posedge clk); #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule